// File: doc/BRIEF.md
# PLL Relock Sequencer

This block owns the control bits and divider fields of an on-chip phase-locked loop and changes its frequency setting safely. A request carries a feedback multiplier M, a pre-divider P, a post-divider S and, in the fractional build, a 16-bit fraction K, together with a one-cycle start strobe. When M and P are unchanged, only the post-divider (and fraction) is rewritten in a single cycle. Any other change runs a timed relock. The PLL is held in reset with its output bypassed. The dividers are loaded and a minimum settle interval passes. Reset is then released, the block waits for lock with a timeout, and the bypass is removed.

Two more one-cycle strobes cover power management. Power-up brings a stopped PLL out of reset through the same bypass-and-lock procedure. Power-down puts the PLL back into reset. A done pulse marks the end of every accepted request, and an error pulse marks a lock timeout. The lock input comes from the analog macro, which is asynchronous, so it passes through a two-flop synchronizer before use. The settle and timeout intervals are given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset, reset-bar, bypass, lock-select, busy, done, error and prepared are all 0, and the divider outputs hold the INIT_M, INIT_P, INIT_S and INIT_K parameter values.
- R2: A start whose M and P equal the current pll_m and pll_p changes only pll_s, one cycle after the start edge. Done pulses in that same cycle, busy stays 0, and reset-bar, bypass and pll_m/pll_p do not change.
- R3: A start that changes M or P clears reset-bar one cycle after the start edge. In the integer build (FRAC=0), lock-select is set to 1 in that same cycle. Bypass rises one cycle later, and the new M/P/S appear one cycle after that.
- R4: Reset-bar rises exactly SETTLE_CYC = max(1, ceil(CLK_HZ*T_RST_US/1e6)) cycles after the new dividers appear, and only while bypass is 1.
- R5: Bypass is cleared, with a done pulse in the same cycle, only after the synchronized lock input is seen high. This happens no sooner than two cycles after the PLL raises lock.
- R6: If lock is not seen within LOCK_CYC = ceil(CLK_HZ*T_LOCK_US/1e6) cycles after reset-bar rises, error and done pulse together exactly LOCK_CYC cycles after the rise. Bypass and reset-bar both stay 1.
- R7: A power-up request while reset-bar is 1 pulses done one cycle later and changes no output.
- R8: A power-up request while reset-bar is 0 first sets bypass. Reset-bar rises one cycle later, and then the lock wait of R5 runs.
- R9: A power-down request clears reset-bar one cycle after its edge and pulses done in that cycle.
- R10: A start strobe that arrives while busy is 1 is ignored. The dividers end at the values of the request in progress, and no second sequence follows.
- R11: The prepared output always equals reset-bar.
- R12: In the fractional build (FRAC=1), the S-only path also loads K into pll_k, and lock-select stays 0. In the integer build, pll_k keeps INIT_K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle strobe that requests a new divider setting |
| req_m | input | M_W | Requested feedback multiplier |
| req_p | input | P_W | Requested pre-divider |
| req_s | input | S_W | Requested post-divider shift |
| req_k | input | K_W | Requested fraction (used only when FRAC=1) |
| pwr_up | input | 1 | One-cycle power-up request |
| pwr_dn | input | 1 | One-cycle power-down request |
| pll_lock | input | 1 | Lock status from the PLL, asynchronous |
| pll_rstb | output | 1 | Active-low PLL reset |
| pll_bypass | output | 1 | Routes the reference clock around the PLL |
| pll_lock_sel | output | 1 | Selects the PLL output lock detector |
| pll_m | output | M_W | Multiplier applied to the PLL |
| pll_p | output | P_W | Pre-divider applied to the PLL |
| pll_s | output | S_W | Post-divider applied to the PLL |
| pll_k | output | K_W | Fraction applied to the PLL |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse at the end of an accepted request |
| err | output | 1 | One-cycle pulse when the lock wait times out |
| prepared | output | 1 | Mirrors reset-bar |

## Verification
The bench walks a full relock one cycle at a time. It records the cycle in which each of reset-bar, bypass, the dividers and done changes. This catches a design that reorders steps or runs the settle count one cycle short or long. It also catches one that drops bypass before the synchronized lock, which would send an unlocked clock downstream.

The timeout case holds lock low past the limit. A wrong design would clear bypass, miss the error pulse, or fire it at the wrong cycle. The S-only path is run both while the PLL is stopped and while it is running. A design that wrongly starts a relock there would toggle reset-bar.

The remaining tests cover a second start sent in mid-sequence, power-up on a PLL that is already running, and the fraction field in the fractional build. A design that accepts the mid-sequence start would leave the wrong multiplier. One that restarts an already running PLL would disturb it, and one that ignores the fraction would leave K unchanged.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_BYP    = 3'd1,
      ST_PROG   = 3'd2,
      ST_SETTLE = 3'd3,
      ST_PU_REL = 3'd4,
      ST_LOCK   = 3'd5
   } seq_state_e;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pll_lock_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pll_interval_cnt.sv
module pll_interval_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   if (CNT_W < 1) begin : g_bad_width
      $error("pll_interval_cnt: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
   import pll_seq_pkg::*;
#(
   parameter int          M_W        = 10,
   parameter int          P_W        = 6,
   parameter int          S_W        = 3,
   parameter int          K_W        = 16,
   parameter bit          FRAC       = 1'b0,
   parameter logic [9:0]  INIT_M     = 10'd200,
   parameter logic [5:0]  INIT_P     = 6'd3,
   parameter logic [2:0]  INIT_S     = 3'd1,
   parameter logic [15:0] INIT_K     = 16'd0,
   parameter int          CNT_W      = 8,
   parameter int          SETTLE_CYC = 3,
   parameter int          LOCK_CYC   = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_start,
   input  logic [M_W-1:0]   req_m,
   input  logic [P_W-1:0]   req_p,
   input  logic [S_W-1:0]   req_s,
   input  logic [K_W-1:0]   req_k,
   input  logic             pwr_up,
   input  logic             pwr_dn,
   input  logic             lock_ok,
   input  logic             tmr_exp,
   output logic             tmr_clr,
   output logic [CNT_W-1:0] tmr_limit,
   output logic             pll_rstb,
   output logic             pll_bypass,
   output logic             pll_lock_sel,
   output logic [M_W-1:0]   pll_m,
   output logic [P_W-1:0]   pll_p,
   output logic [S_W-1:0]   pll_s,
   output logic [K_W-1:0]   pll_k,
   output logic             busy,
   output logic             done,
   output logic             err
);
   seq_state_e state_q, state_d;
   logic [M_W-1:0] lat_m;
   logic [P_W-1:0] lat_p;
   logic [S_W-1:0] lat_s;
   logic [K_W-1:0] lat_k;
   logic mp_same, accept, k_load_now, k_load_lat, lsel_set;

   assign mp_same = (req_m == pll_m) && (req_p == pll_p);
   assign accept  = (state_q == ST_IDLE) && req_start;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req_start) begin
               if (!mp_same) state_d = ST_BYP;
            end else if (pwr_up && !pll_rstb) begin
               state_d = ST_PU_REL;
            end
         end
         ST_BYP:    state_d = ST_PROG;
         ST_PROG:   state_d = ST_SETTLE;
         ST_SETTLE: if (tmr_exp) state_d = ST_LOCK;
         ST_PU_REL: state_d = ST_LOCK;
         ST_LOCK:   if (lock_ok || tmr_exp) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   assign tmr_clr   = (state_d != state_q) ||
                      !((state_q == ST_SETTLE) || (state_q == ST_LOCK));
   assign tmr_limit = (state_q == ST_LOCK) ? CNT_W'(LOCK_CYC) : CNT_W'(SETTLE_CYC);
   assign busy      = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pll_rstb   <= 1'b0;
         pll_bypass <= 1'b0;
         pll_m      <= M_W'(INIT_M);
         pll_p      <= P_W'(INIT_P);
         pll_s      <= S_W'(INIT_S);
         lat_m      <= '0;
         lat_p      <= '0;
         lat_s      <= '0;
         lat_k      <= '0;
         done       <= 1'b0;
         err        <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= 1'b0;
         err     <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_start) begin
                  lat_m <= req_m;
                  lat_p <= req_p;
                  lat_s <= req_s;
                  lat_k <= req_k;
                  if (mp_same) begin
                     pll_s <= req_s;
                     done  <= 1'b1;
                  end else begin
                     pll_rstb <= 1'b0;
                  end
               end else if (pwr_up) begin
                  if (pll_rstb) done <= 1'b1;
                  else          pll_bypass <= 1'b1;
               end else if (pwr_dn) begin
                  pll_rstb <= 1'b0;
                  done     <= 1'b1;
               end
            end
            ST_BYP:  pll_bypass <= 1'b1;
            ST_PROG: begin
               pll_m <= lat_m;
               pll_p <= lat_p;
               pll_s <= lat_s;
            end
            ST_SETTLE: if (tmr_exp) pll_rstb <= 1'b1;
            ST_PU_REL: pll_rstb <= 1'b1;
            ST_LOCK: begin
               if (lock_ok) begin
                  pll_bypass <= 1'b0;
                  done       <= 1'b1;
               end else if (tmr_exp) begin
                  err  <= 1'b1;
                  done <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign k_load_now = accept && mp_same;
   assign k_load_lat = (state_q == ST_PROG);
   assign lsel_set   = accept && !mp_same;

   if (FRAC) begin : g_frac
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pll_k <= K_W'(INIT_K);
         else if (k_load_now) pll_k <= req_k;
         else if (k_load_lat) pll_k <= lat_k;
      end
      assign pll_lock_sel = 1'b0;
   end else begin : g_int
      logic lsel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        lsel_q <= 1'b0;
         else if (lsel_set) lsel_q <= 1'b1;
      end
      assign pll_lock_sel = lsel_q;
      assign pll_k        = K_W'(INIT_K);
   end

   // R3
   mp_change_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({pll_m, pll_p}) |-> (!pll_rstb && pll_bypass));

   // R4
   release_under_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_rstb) |-> pll_bypass);

   // R5
   unbypass_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_bypass) |-> $past(lock_ok));

   // R6
   err_keeps_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && pll_bypass && pll_rstb));

   // R10
   no_start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_start && state_q != ST_PROG) |=> $stable({pll_m, pll_p}));
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq #(
   parameter int unsigned CLK_HZ    = 100_000_000,
   parameter int unsigned T_RST_US  = 3,
   parameter int unsigned T_LOCK_US = 10000,
   parameter int          M_W       = 10,
   parameter int          P_W       = 6,
   parameter int          S_W       = 3,
   parameter int          K_W       = 16,
   parameter bit          FRAC      = 1'b0,
   parameter logic [9:0]  INIT_M    = 10'd200,
   parameter logic [5:0]  INIT_P    = 6'd3,
   parameter logic [2:0]  INIT_S    = 3'd1,
   parameter logic [15:0] INIT_K    = 16'd0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_start,
   input  logic [M_W-1:0] req_m,
   input  logic [P_W-1:0] req_p,
   input  logic [S_W-1:0] req_s,
   input  logic [K_W-1:0] req_k,
   input  logic           pwr_up,
   input  logic           pwr_dn,
   input  logic           pll_lock,
   output logic           pll_rstb,
   output logic           pll_bypass,
   output logic           pll_lock_sel,
   output logic [M_W-1:0] pll_m,
   output logic [P_W-1:0] pll_p,
   output logic [S_W-1:0] pll_s,
   output logic [K_W-1:0] pll_k,
   output logic           busy,
   output logic           done,
   output logic           err,
   output logic           prepared
);
   localparam longint unsigned SET_RAW  = (longint'(CLK_HZ) * T_RST_US + 64'd999_999) / 64'd1_000_000;
   localparam longint unsigned LOCK_RAW = (longint'(CLK_HZ) * T_LOCK_US + 64'd999_999) / 64'd1_000_000;
   localparam int SETTLE_CYC = (SET_RAW  < 1) ? 1 : int'(SET_RAW);
   localparam int LOCK_CYC   = (LOCK_RAW < 1) ? 1 : int'(LOCK_RAW);
   localparam int MAX_CYC    = (LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC;
   localparam int CNT_W      = $clog2(MAX_CYC + 1);

   if (T_RST_US == 0 || T_LOCK_US == 0 || CLK_HZ == 0) begin : g_bad_time
      $error("pll_relock_seq: clock and intervals must be non-zero");
   end
   if (M_W > 10 || P_W > 6 || S_W > 3 || K_W > 16) begin : g_bad_field
      $error("pll_relock_seq: field widths exceed initial value widths");
   end

   logic             lock_ok, tmr_exp, tmr_clr;
   logic [CNT_W-1:0] tmr_limit;

   pll_lock_sync #(.STAGES(2)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pll_lock), .sync_out(lock_ok)
   );

   pll_interval_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit), .expired(tmr_exp)
   );

   pll_seq_fsm #(
      .M_W(M_W), .P_W(P_W), .S_W(S_W), .K_W(K_W), .FRAC(FRAC),
      .INIT_M(INIT_M), .INIT_P(INIT_P), .INIT_S(INIT_S), .INIT_K(INIT_K),
      .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_start(req_start), .req_m(req_m), .req_p(req_p), .req_s(req_s), .req_k(req_k),
      .pwr_up(pwr_up), .pwr_dn(pwr_dn),
      .lock_ok(lock_ok), .tmr_exp(tmr_exp), .tmr_clr(tmr_clr), .tmr_limit(tmr_limit),
      .pll_rstb(pll_rstb), .pll_bypass(pll_bypass), .pll_lock_sel(pll_lock_sel),
      .pll_m(pll_m), .pll_p(pll_p), .pll_s(pll_s), .pll_k(pll_k),
      .busy(busy), .done(done), .err(err)
   );

   assign prepared = pll_rstb;
endmodule

// File: tb/test_pll_relock_seq.sv
module test_pll_relock_seq;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE_EXP = 6;      // 2 MHz * 3 us
   localparam int LOCK_EXP   = 20000;  // 2 MHz * 10 ms

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 1'b0, pwr_up = 1'b0, pwr_dn = 1'b0;
   logic [9:0]  req_m = '0;
   logic [5:0]  req_p = '0;
   logic [2:0]  req_s = '0;
   logic [15:0] req_k = '0;
   logic pll_lock = 1'b0;
   logic pll_rstb, pll_bypass, pll_lock_sel, busy, done, err, prepared;
   logic [9:0] pll_m; logic [5:0] pll_p; logic [2:0] pll_s; logic [15:0] pll_k;
   logic f_rstb, f_byp, f_lsel, f_busy, f_done, f_err, f_prep;
   logic [9:0] f_m; logic [5:0] f_p; logic [2:0] f_s; logic [15:0] f_k;

   int checks = 0, errors = 0, cyc = 0;
   int lock_dly = 4, lcnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_relock_seq #(.CLK_HZ(2_000_000), .FRAC(1'b0)) i_pll_relock_seq (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_m(req_m), .req_p(req_p),
      .req_s(req_s), .req_k(req_k), .pwr_up(pwr_up), .pwr_dn(pwr_dn), .pll_lock(pll_lock),
      .pll_rstb(pll_rstb), .pll_bypass(pll_bypass), .pll_lock_sel(pll_lock_sel),
      .pll_m(pll_m), .pll_p(pll_p), .pll_s(pll_s), .pll_k(pll_k),
      .busy(busy), .done(done), .err(err), .prepared(prepared));

   pll_relock_seq #(.CLK_HZ(2_000_000), .FRAC(1'b1)) i_pll_relock_seq_frac (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_m(req_m), .req_p(req_p),
      .req_s(req_s), .req_k(req_k), .pwr_up(pwr_up), .pwr_dn(pwr_dn), .pll_lock(1'b0),
      .pll_rstb(f_rstb), .pll_bypass(f_byp), .pll_lock_sel(f_lsel),
      .pll_m(f_m), .pll_p(f_p), .pll_s(f_s), .pll_k(f_k),
      .busy(f_busy), .done(f_done), .err(f_err), .prepared(f_prep));

   // PLL model: lock rises lock_dly+1 edges after reset-bar goes high
   always @(posedge clk) begin
      if (!pll_rstb) begin lcnt <= 0; pll_lock <= 1'b0; end
      else if (lcnt >= lock_dly) pll_lock <= 1'b1;
      else lcnt <= lcnt + 1;
   end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic t_reset;
      chk(pll_rstb == 0 && pll_bypass == 0 && pll_lock_sel == 0, "R1 ctrl", {pll_rstb, pll_bypass, pll_lock_sel}, 0);
      chk(busy == 0 && done == 0 && err == 0, "R1 status", {busy, done, err}, 0);
      chk(pll_m == 200 && pll_p == 3 && pll_s == 1 && pll_k == 0, "R1 dividers", pll_m, 200);
      chk(prepared == pll_rstb, "R11 reset", prepared, pll_rstb);
   endtask

   task automatic t_s_only(input logic [2:0] s, input logic [15:0] k);
      logic rb, by; logic [9:0] m0;
      rb = pll_rstb; by = pll_bypass; m0 = pll_m;
      req_m = pll_m; req_p = pll_p; req_s = s; req_k = k; req_start = 1'b1;
      @(negedge clk); req_start = 1'b0;
      chk(pll_s == s, "R2 s", pll_s, s);
      chk(done == 1 && busy == 0, "R2 done", {done, busy}, 2);
      chk(pll_rstb == rb && pll_bypass == by && pll_m == m0, "R2 untouched", {pll_rstb, pll_bypass}, {rb, by});
      chk(pll_k == 0, "R12 int k", pll_k, 0);
      if (rb == 1'b0) begin
         chk(f_k == k && f_s == s, "R12 frac k", f_k, k);
         chk(f_lsel == 0, "R12 frac lock-sel", f_lsel, 0);
      end
      @(negedge clk);
   endtask

   task automatic t_pwr_up_cold;
      int t_byp = -1, t_rel = -1, t_done = -1;
      pwr_up = 1'b1;
      @(negedge clk); pwr_up = 1'b0;
      for (int i = 1; i < 200 && t_done < 0; i++) begin
         if (t_byp < 0 && pll_bypass) t_byp = i;
         if (t_rel < 0 && pll_rstb) t_rel = i;
         if (done) t_done = i;
         if (t_done < 0) @(negedge clk);
      end
      chk(t_byp == 1, "R8 bypass first", t_byp, 1);
      chk(t_rel == 2, "R8 release next", t_rel, 2);
      chk(t_done - t_rel >= lock_dly + 2 && t_done - t_rel <= lock_dly + 8, "R5 pu lock wait", t_done - t_rel, lock_dly + 4);
      chk(pll_bypass == 0 && prepared == 1, "R11 prepared up", prepared, 1);
      @(negedge clk);
   endtask

   task automatic t_pwr_up_warm;
      logic [9:0] m0; m0 = pll_m;
      pwr_up = 1'b1;
      @(negedge clk); pwr_up = 1'b0;
      chk(done == 1 && busy == 0, "R7 done", done, 1);
      chk(pll_rstb == 1 && pll_bypass == 0 && pll_m == m0, "R7 untouched", {pll_rstb, pll_bypass}, 2);
      @(negedge clk);
   endtask

   task automatic t_full(input logic [9:0] m, input logic [5:0] p, input logic [2:0] s,
                         input bit expect_err, input bit poke_busy);
      int t_lo = -1, t_byp = -1, t_div = -1, t_rel = -1, t_done = -1;
      bit lsel_at_lo = 0, err_seen = 0, byp_end = 0;
      req_m = m; req_p = p; req_s = s; req_start = 1'b1;
      @(negedge clk); req_start = 1'b0;
      for (int i = 1; i < LOCK_EXP + 200 && t_done < 0; i++) begin
         if (t_lo < 0 && !pll_rstb) begin t_lo = i; lsel_at_lo = pll_lock_sel; end
         if (t_byp < 0 && pll_bypass) t_byp = i;
         if (t_div < 0 && pll_m == m && pll_p == p && pll_s == s) t_div = i;
         if (t_lo >= 0 && t_rel < 0 && pll_rstb) t_rel = i;
         if (done) begin t_done = i; err_seen = err; byp_end = pll_bypass; end
         if (t_done < 0) begin
            if (poke_busy && i == 1) begin req_m = m + 10'd50; req_start = 1'b1; end
            @(negedge clk);
            req_start = 1'b0;
         end
      end
      chk(t_lo == 1, "R3 reset first", t_lo, 1);
      chk(lsel_at_lo == 1, "R3 lock-sel", lsel_at_lo, 1);
      chk(t_byp == 2, "R3 bypass second", t_byp, 2);
      chk(t_div == 3, "R3 dividers third", t_div, 3);
      chk(t_rel - t_div == SETTLE_EXP, "R4 settle", t_rel - t_div, SETTLE_EXP);
      if (!expect_err) begin
         chk(t_done - t_rel >= lock_dly + 2 && t_done - t_rel <= lock_dly + 8, "R5 lock wait", t_done - t_rel, lock_dly + 4);
         chk(byp_end == 0 && err_seen == 0, "R5 unbypass", {byp_end, err_seen}, 0);
      end else begin
         chk(t_done - t_rel == LOCK_EXP, "R6 timeout cycle", t_done - t_rel, LOCK_EXP);
         chk(err_seen == 1 && byp_end == 1 && pll_rstb == 1, "R6 error state", {err_seen, byp_end, pll_rstb}, 7);
      end
      if (poke_busy) begin
         for (int j = 0; j < 10; j++) @(negedge clk);
         chk(pll_m == m && busy == 0 && pll_rstb == 1 && pll_bypass == 0, "R10 ignored start", pll_m, m);
      end
      @(negedge clk);
   endtask

   task automatic t_pwr_dn;
      pwr_dn = 1'b1;
      @(negedge clk); pwr_dn = 1'b0;
      chk(pll_rstb == 0 && done == 1, "R9 power-down", {pll_rstb, done}, 1);
      chk(prepared == 0, "R11 prepared down", prepared, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_s_only(3'd2, 16'h4000);            // R2, R12 with PLL stopped
      t_pwr_up_cold();                      // R8
      t_pwr_up_warm();                      // R7
      t_full(10'd250, 6'd3, 3'd1, 0, 1);    // R3 R4 R5 R10
      t_s_only(3'd0, 16'h0001);             // R2 with PLL running
      lock_dly = 30000;
      t_full(10'd300, 6'd2, 3'd2, 1, 0);    // R6
      lock_dly = 4;
      t_pwr_dn();                           // R9
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule